// File: doc/BRIEF.md
# Real-Time Clock Periodic Interrupt Generator

This block produces the periodic interrupt of a real-time clock. It runs from a 32.768 kHz timebase that reaches it as a single-cycle tick enable on the system clock. A 4-bit rate code and an enable bit choose the event period. The period is always a power of two: codes 3 to 15 give 2^(code-1) ticks, codes 1 and 2 stand in for the 128-tick and 256-tick rates, and code 0 switches periodic events off.

A free-running 15-bit tick counter sets when events occur. An event happens on the tick that carries this counter onto a multiple of the period. Changing the rate therefore never restarts the phase. Each event sets two sticky flags and raises the interrupt request. The flags stay set until a clear pulse arrives. An external inhibit input suppresses events, so it can stop the request from rising. It never stops the request from falling.

Top module: `rtc_periodic_gen`

## Requirements
- R1: In reset and on the first cycle after reset, `flags_o` is 2'b00, `irq_o` is low, `event_o` is low, and the internal tick count is 0.
- R2: With rate code 0, no event ever occurs, whatever the other inputs are.
- R3: Rate code 1 gives a period of 128 ticks. Rate code 2 gives a period of 256 ticks.
- R4: Rate codes 3 to 15 give a period of 2^(code-1) ticks, from 4 ticks for code 3 up to 16384 ticks for code 15.
- R5: The tick count advances by one on each cycle where `tick_i` is high and wraps from 32767 to 0. An event occurs only on a tick that moves the count onto a multiple of the period. Two such ticks are therefore one full period apart.
- R6: While `enable_i` is low, no event occurs.
- R7: An event raises `event_o` for exactly one cycle, in the cycle after the qualifying tick. In that same cycle, `flags_o` becomes 2'b11. Bit 1 is the interrupt-request flag and bit 0 is the periodic flag. `irq_o` goes high.
- R8: Once set, the flags and `irq_o` stay set until a cycle with `clear_i` high. That cycle clears both flags and lowers `irq_o` one cycle later. If an event and a clear occur in the same cycle, the event wins.
- R9: While `inhibit_i` is high, no event occurs and `irq_o` cannot rise. An `irq_o` that is already high stays high, and `clear_i` still lowers it.
- R10: A change of rate code or enable bit causes no event in the cycle it is applied unless that cycle is a qualifying tick under the new setting. The new period takes effect from the next multiple of that period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle enable per 32.768 kHz period |
| rate_i | input | 4 | Rate code; 0 disables events |
| enable_i | input | 1 | Periodic interrupt enable |
| inhibit_i | input | 1 | Suppresses events and blocks the request from rising |
| clear_i | input | 1 | Clears both flags and the request |
| flags_o | output | 2 | {interrupt-request flag, periodic flag} |
| irq_o | output | 1 | Interrupt request |
| event_o | output | 1 | One-cycle pulse per periodic event |

## Verification
Several errors are targeted directly. If the code 1 and code 2 remap were missing, those codes would fire every tick or every other tick, not every 128 or 256 ticks. An error of one in the period exponent would halve or double the spacing of events at code 3 and code 15. If events were timed from the moment the rate was written, and not from the free-running count, rate changes in the middle of a period would fire early. The random phase is built to catch exactly that. Other tests run the request with inhibit raised after the request went high, and apply clear and event in the same cycle. A design that blocked the falling edge would leave the request stuck. A design that let clear win would drop a real event.

// File: rtl/rtc_pit_pkg.sv
package rtc_pit_pkg;
    localparam int RATE_W = 4;
    localparam int CNT_W  = 15;
    localparam int SH_W   = $clog2(CNT_W) + 1;

    // Codes that stand in for the slow rates below the fastest useful one.
    localparam int ALIAS1_SHIFT = 7;
    localparam int ALIAS2_SHIFT = 8;

    typedef struct packed {
        logic       evt;
        logic [1:0] flg;
    } evt_state_t;

    // Shift (log2 of period) for a nonzero rate code.
    function automatic logic [SH_W-1:0] rate_shift(input logic [RATE_W-1:0] code);
        logic [SH_W-1:0] sh;
        case (code)
            RATE_W'(1): sh = SH_W'(ALIAS1_SHIFT);
            RATE_W'(2): sh = SH_W'(ALIAS2_SHIFT);
            default:    sh = SH_W'(code) - SH_W'(1);
        endcase
        return sh;
    endfunction
endpackage

// File: rtl/rtc_pit_decode.sv
module rtc_pit_decode
    import rtc_pit_pkg::*;
#(
    parameter int RW = RATE_W,
    parameter int CW = CNT_W
) (
    input  logic [RW-1:0] rate_i,
    output logic          active_o,
    output logic [CW-1:0] mask_o
);
    localparam int SW = SH_W;

    logic [SW-1:0] shift;

    always_comb begin
        active_o = (rate_i != '0);
        shift    = rate_shift(rate_i);
    end

    // Bit i of the mask is set when i lies below the period exponent.
    for (genvar i = 0; i < CW; i++) begin : g_mask
        assign mask_o[i] = active_o && (SW'(i) < shift);
    end

    always_comb begin
        if (active_o) begin
            AST_MIN_PERIOD: assert (mask_o[1:0] == 2'b11); // R4
        end
    end
endmodule

// File: rtl/rtc_pit_timebase.sv
module rtc_pit_timebase
    import rtc_pit_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic [CW-1:0] mask_i,
    output logic          edge_o
);
    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        cnt_inc = cnt_q + CW'(1);
        cnt_d   = tick_i ? cnt_inc : cnt_q;
        edge_o  = tick_i && ((cnt_inc & mask_i) == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (cnt_q == $past(cnt_q) + CW'(1))); // R5
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/rtc_pit_event.sv
module rtc_pit_event
    import rtc_pit_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       edge_i,
    input  logic       active_i,
    input  logic       enable_i,
    input  logic       inhibit_i,
    input  logic       clear_i,
    output logic       evt_o,
    output logic [1:0] flg_o
);
    evt_state_t st_d, st_q;
    logic       fire;

    always_comb begin
        fire     = edge_i && active_i && enable_i && !inhibit_i;
        st_d     = st_q;
        st_d.evt = fire;
        if (fire)         st_d.flg = 2'b11;
        else if (clear_i) st_d.flg = 2'b00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt_o = st_q.evt;
    assign flg_o = st_q.flg;

    AST_EVT_SETS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> (flg_o == 2'b11)); // R7
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_o != 2'b00 && !clear_i) |=> (flg_o == 2'b11)); // R8
    AST_CLEAR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !edge_i) |=> (flg_o == 2'b00)); // R8
endmodule

// File: rtl/rtc_periodic_gen.sv
module rtc_periodic_gen
    import rtc_pit_pkg::*;
#(
    parameter int RW = RATE_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic [RW-1:0] rate_i,
    input  logic          enable_i,
    input  logic          inhibit_i,
    input  logic          clear_i,
    output logic [1:0]    flags_o,
    output logic          irq_o,
    output logic          event_o
);
    logic          active;
    logic [CW-1:0] mask;
    logic          edge_hit;

    rtc_pit_decode #(.RW(RW), .CW(CW)) u_decode (
        .rate_i   (rate_i),
        .active_o (active),
        .mask_o   (mask)
    );

    rtc_pit_timebase #(.CW(CW)) u_timebase (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .mask_i (mask),
        .edge_o (edge_hit)
    );

    rtc_pit_event u_event (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_i    (edge_hit),
        .active_i  (active),
        .enable_i  (enable_i),
        .inhibit_i (inhibit_i),
        .clear_i   (clear_i),
        .evt_o     (event_o),
        .flg_o     (flags_o)
    );

    assign irq_o = flags_o[1];

    AST_CODE0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_i == '0) |=> !event_o); // R2
    AST_NO_TICK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> !event_o); // R5
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !event_o); // R6
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |=> !event_o); // R7
    AST_INHIBIT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_i |=> !$rose(irq_o)); // R9
endmodule

// File: tb/rtc_periodic_gen_test.sv
module rtc_periodic_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [3:0] rate_i = 4'd0;
    logic       enable_i = 1'b0;
    logic       inhibit_i = 1'b0;
    logic       clear_i = 1'b0;
    logic [1:0] flags_o;
    logic       irq_o;
    logic       event_o;

    int n_run = 0;
    int n_fail = 0;
    int cnt_m = 0;
    bit exp_evt = 0;
    bit [1:0] exp_flg = 0;
    int ev_seen = 0;

    always #10 clk = ~clk;

    rtc_periodic_gen uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rate_i(rate_i),
        .enable_i(enable_i), .inhibit_i(inhibit_i), .clear_i(clear_i),
        .flags_o(flags_o), .irq_o(irq_o), .event_o(event_o)
    );

    function automatic int period_of(input logic [3:0] code);
        if (code == 4'd0) return 0;
        if (code == 4'd1) return 128;
        if (code == 4'd2) return 256;
        return 1 << (int'(code) - 1);
    endfunction

    task automatic check(input string tag, input int act, input int exp_v, input string what);
        n_run++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp_v);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
    task automatic step(input bit tk, input logic [3:0] cd, input bit en,
                        input bit ih, input bit cl, input string tag);
        int per;
        bit fire;
        tick_i = tk; rate_i = cd; enable_i = en; inhibit_i = ih; clear_i = cl;
        per  = period_of(cd);
        fire = tk && en && !ih && per != 0 && (((cnt_m + 1) % per) == 0);
        @(posedge clk);
        @(negedge clk);
        exp_evt = fire;
        if (fire)    exp_flg = 2'b11;
        else if (cl) exp_flg = 2'b00;
        if (tk) cnt_m = (cnt_m + 1) % 32768;
        if (event_o) ev_seen++;
        check(tag, {29'd0, event_o, flags_o}, {29'd0, exp_evt, exp_flg}, "event/flags");
        check(tag, int'(irq_o), int'(exp_flg[1]), "irq");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check("R1", {29'd0, event_o, flags_o}, 0, "reset outputs");
        rst_n = 1'b1;
        step(0, 4'd0, 0, 0, 0, "R1");

        // R4: code 3, every fourth tick; 40 ticks from count 0 give 10 events
        ev_seen = 0;
        for (int i = 0; i < 40; i++) step(1, 4'd3, 1, 0, 1, "R4");
        check("R4", ev_seen, 10, "code3 event count");

        // R3: alias codes
        ev_seen = 0;
        for (int i = 0; i < 300; i++) step(1, 4'd1, 1, 0, 1, "R3");
        check("R3", ev_seen, 2, "code1 event count");   // multiples of 128 in (40,340]
        ev_seen = 0;
        for (int i = 0; i < 300; i++) step(1, 4'd2, 1, 0, 1, "R3");
        check("R3", ev_seen, 1, "code2 event count");   // 512 in (340,640]

        // R2 and R6: code 0 and disabled
        ev_seen = 0;
        for (int i = 0; i < 260; i++) step(1, 4'd0, 1, 0, 1, "R2");
        check("R2", ev_seen, 0, "code0 events");
        for (int i = 0; i < 260; i++) step(1, 4'd3, 0, 0, 1, "R6");
        check("R6", ev_seen, 0, "disabled events");

        // R8: flags persist until cleared, event beats clear
        while (exp_flg == 2'b00) step(1, 4'd3, 1, 0, 0, "R7");
        for (int i = 0; i < 10; i++) step(0, 4'd3, 1, 0, 0, "R8");
        step(0, 4'd3, 1, 0, 1, "R8");
        check("R8", int'(flags_o), 0, "cleared");
        while ((cnt_m + 1) % 4 != 0) step(1, 4'd3, 1, 0, 0, "R8");
        step(1, 4'd3, 1, 0, 1, "R8");
        check("R8", int'(flags_o), 3, "event wins over clear");

        // R9: inhibit keeps raised request high; clear still lowers it
        for (int i = 0; i < 20; i++) step(1, 4'd3, 1, 1, 0, "R9");
        check("R9", int'(irq_o), 1, "request held under inhibit");
        step(1, 4'd3, 1, 1, 1, "R9");
        check("R9", int'(irq_o), 0, "clear under inhibit");
        ev_seen = 0;
        for (int i = 0; i < 40; i++) step(1, 4'd3, 1, 1, 0, "R9");
        check("R9", ev_seen + int'(irq_o), 0, "no rise under inhibit");

        // R4: code 15, longest period
        ev_seen = 0;
        for (int i = 0; i < 16384; i++) step(1, 4'd15, 1, 0, 1, "R4");
        check("R4", ev_seen, 1, "code15 one event per 16384 ticks");

        // R10: switch rate mid-period, only the new boundary counts
        step(1, 4'd6, 1, 0, 1, "R10");
        for (int i = 0; i < 70; i++) step(1, 4'd4, 1, 0, 1, "R10");

        // R5 and R10: random mix across the wrap of the count
        for (int i = 0; i < 40000; i++) begin
            logic [3:0] cd;
            cd = ($urandom % 4 == 0) ? 4'($urandom) : 4'(3 + $urandom % 3);
            step(($urandom % 4) != 0, cd, ($urandom % 8) != 0,
                 ($urandom % 10) == 0, ($urandom % 6) == 0, "R5");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule